// File: doc/BRIEF.md
# Command Slot Dispatcher

This block hands queued commands of one storage port to an execution engine. Software posts work by writing a bit mask into the issue register. The mask is merged into a 32-entry pending bitmap, one bit for each command slot. While the port's run bit is on, a scanner walks the pending slots in ascending order. It offers each slot to the engine, one at a time, over a request/acknowledge pair.

The engine answers each offer with an acknowledge. The acknowledge either reports the command finished, so its pending bit is cleared, or reports it still running. A running command becomes the single tracked busy slot, and its pending bit is kept. The bit is retired only when a later completion event arrives and the engine status shows neither busy nor data-request. That event also starts a fresh scan. No slot is offered while the engine reports busy or data-request, and the port's local reset forgets the busy slot.

Top module: `slot_dispatch`

## Requirements
- R1: An issue-register write ORs the written mask into the pending bitmap; it never clears a bit. When a write and a clear hit the same bit in one cycle, the bit ends up set.
- R2: A slot is offered only when the run bit is 1 and the bitmap is non-zero. A scan starts after a command-register write, an issue-register write or a completion event. Setting issue bits while the run bit is 0 offers nothing.
- R3: Within one scan, slots are offered in ascending index order starting from slot 0. At most one offer is outstanding at a time, and `offer_slot` holds steady until `offer_ack`.
- R4: If `eng_bsy` or `eng_drq` is 1 when the next pending slot comes up, that slot is not offered, its bit stays set and the scan ends.
- R5: An acknowledge with `offer_running` = 0 clears the offered slot's pending bit.
- R6: An acknowledge with `offer_running` = 1 records the offered slot as the busy slot (`busy_valid` = 1, `busy_slot` = index) and keeps its pending bit.
- R7: A `done_evt` pulse while a busy slot is held and both `eng_bsy` and `eng_drq` are 0 clears that slot's pending bit, sets `busy_valid` to 0 and starts a new scan.
- R8: A `done_evt` pulse while `eng_bsy` or `eng_drq` is 1 leaves the busy slot and the pending bitmap unchanged.
- R9: A `port_rst` pulse sets `busy_valid` to 0 on the next cycle. The pending bitmap is left as it was.
- R10: After the synchronous reset, the pending bitmap is 0, no offer is made, no busy slot is held and the run bit is 0.
- R11: A scan ends once no pending slot remains at or above the next index, which includes the case after slot 31 has been offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command-register write strobe |
| cmd_start | input | 1 | Run bit value written with `cmd_wr` |
| issue_wr | input | 1 | Issue-register write strobe |
| issue_data | input | NSLOT | Mask of slots to add to the pending bitmap |
| done_evt | input | 1 | Completion event from the engine |
| port_rst | input | 1 | Port-level reset pulse; drops the busy slot |
| eng_bsy | input | 1 | Engine status: busy |
| eng_drq | input | 1 | Engine status: data request |
| offer_ack | input | 1 | Engine has taken the offered slot |
| offer_running | input | 1 | With `offer_ack`: 1 = command still running, 0 = finished |
| offer_valid | output | 1 | A slot is being offered |
| offer_slot | output | SW | Index of the offered slot |
| issue_bits | output | NSLOT | Pending bitmap as read by software |
| busy_valid | output | 1 | A busy slot is held |
| busy_slot | output | SW | Index of the busy slot |

## Verification
The checker watches the following rules on every cycle:
- issue writes only add bits;
- an offer never starts with the run bit off or the engine stalled;
- the offered index holds until it is acknowledged;
- an acknowledge clears the pending bit or records the busy slot;
- a port reset or a completion with the engine idle drops the busy slot;
- a completion while the engine is stalled leaves the busy slot alone.

Other behaviours only show across whole scenarios, so the bench's reference model and its logged offer order cover them:
- the ascending order within a scan and the early end of a scan;
- the rescan after a completion, which dispatches the slot that was refused earlier;
- the handling of slot 31.

// File: rtl/slot_dispatch_pkg.sv
package slot_dispatch_pkg;

    // Scanner phases: waiting for a trigger, searching the bitmap, offer outstanding
    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_SEEK  = 2'd1,
        SC_OFFER = 2'd2
    } scan_state_e;

endpackage

// File: rtl/issue_bitmap.sv
module issue_bitmap #(
    parameter int NSLOT = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSLOT-1:0] set_mask,
    input  logic [NSLOT-1:0] clr_mask,
    output logic [NSLOT-1:0] bits
);
    // A software set outranks a clear of the same bit in the same cycle
    always_ff @(posedge clk) begin
        if (rst) bits <= '0;
        else     bits <= (bits & ~clr_mask) | set_mask;
    end
endmodule

// File: rtl/slot_pick.sv
module slot_pick #(
    parameter int NSLOT = 32,
    parameter int SW    = 5
) (
    input  logic [NSLOT-1:0] bits,
    input  logic [SW:0]      floor_idx,
    output logic             hit,
    output logic [SW-1:0]    idx
);
    logic [NSLOT-1:0] elig;

    // Only slots at or above the scan cursor are candidates
    for (genvar i = 0; i < NSLOT; i++) begin : g_elig
        localparam logic [SW:0] POS = (SW+1)'(i);
        assign elig[i] = bits[i] && (POS >= floor_idx);
    end

    // Lowest eligible index wins
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (elig[i]) begin
                hit = 1'b1;
                idx = SW'(i);
            end
        end
    end
endmodule

// File: rtl/busy_tracker.sv
module busy_tracker #(
    parameter int SW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          port_rst,
    input  logic          rec_en,
    input  logic [SW-1:0] rec_idx,
    input  logic          drop_en,
    output logic          valid,
    output logic [SW-1:0] idx
);
    // Priority: port reset, then a new record, then a retire
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            idx   <= '0;
        end else if (port_rst) begin
            valid <= 1'b0;
        end else if (rec_en) begin
            valid <= 1'b1;
            idx   <= rec_idx;
        end else if (drop_en) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/slot_dispatch.sv
module slot_dispatch
    import slot_dispatch_pkg::*;
#(
    parameter int NSLOT = 32,
    localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic             cmd_start,
    input  logic             issue_wr,
    input  logic [NSLOT-1:0] issue_data,
    input  logic             done_evt,
    input  logic             port_rst,
    input  logic             eng_bsy,
    input  logic             eng_drq,
    input  logic             offer_ack,
    input  logic             offer_running,
    output logic             offer_valid,
    output logic [SW-1:0]    offer_slot,
    output logic [NSLOT-1:0] issue_bits,
    output logic             busy_valid,
    output logic [SW-1:0]    busy_slot
);
    scan_state_e      st_q;
    logic [SW:0]      cur_q;
    logic [SW-1:0]    slot_q;
    logic             run_q;
    logic             kick_q;

    logic             eng_stall;
    logic             done_ok;
    logic             ack_done;
    logic             ack_run;
    logic             kick;
    logic             pick_hit;
    logic [SW-1:0]    pick_idx;
    logic [NSLOT-1:0] set_mask;
    logic [NSLOT-1:0] clr_mask;

    assign eng_stall = eng_bsy | eng_drq;
    assign done_ok   = done_evt & busy_valid & ~eng_stall;
    assign ack_done  = (st_q == SC_OFFER) & offer_ack & ~offer_running;
    assign ack_run   = (st_q == SC_OFFER) & offer_ack & offer_running;
    assign kick      = cmd_wr | issue_wr | done_evt;

    assign set_mask = issue_wr ? issue_data : '0;
    assign clr_mask = (ack_done ? (NSLOT'(1) << slot_q)    : '0)
                    | (done_ok  ? (NSLOT'(1) << busy_slot) : '0);

    issue_bitmap #(.NSLOT(NSLOT)) u_bitmap (
        .clk      (clk),
        .rst      (rst),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .bits     (issue_bits)
    );

    slot_pick #(.NSLOT(NSLOT), .SW(SW)) u_pick (
        .bits      (issue_bits),
        .floor_idx (cur_q),
        .hit       (pick_hit),
        .idx       (pick_idx)
    );

    busy_tracker #(.SW(SW)) u_busy (
        .clk      (clk),
        .rst      (rst),
        .port_rst (port_rst),
        .rec_en   (ack_run),
        .rec_idx  (slot_q),
        .drop_en  (done_ok),
        .valid    (busy_valid),
        .idx      (busy_slot)
    );

    // Run bit follows each command-register write
    always_ff @(posedge clk) begin
        if (rst)         run_q <= 1'b0;
        else if (cmd_wr) run_q <= cmd_start;
    end

    // A trigger seen mid-scan is kept and served once the scanner is idle again
    always_ff @(posedge clk) begin
        if (rst) kick_q <= 1'b0;
        else     kick_q <= kick | (kick_q & (st_q != SC_IDLE));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SC_IDLE;
            cur_q  <= '0;
            slot_q <= '0;
        end else begin
            unique case (st_q)
                SC_IDLE: begin
                    if (kick_q && run_q && (issue_bits != '0)) begin
                        st_q  <= SC_SEEK;
                        cur_q <= '0;
                    end
                end
                SC_SEEK: begin
                    if (!run_q || !pick_hit || eng_stall) begin
                        st_q <= SC_IDLE;
                    end else begin
                        st_q   <= SC_OFFER;
                        slot_q <= pick_idx;
                    end
                end
                SC_OFFER: begin
                    if (offer_ack) begin
                        cur_q <= {1'b0, slot_q} + 1'b1;
                        st_q  <= SC_SEEK;
                    end
                end
                default: st_q <= SC_IDLE;
            endcase
        end
    end

    assign offer_valid = (st_q == SC_OFFER);
    assign offer_slot  = slot_q;

endmodule

// File: rtl/slot_dispatch_chk.sv
module slot_dispatch_chk #(
    parameter int NSLOT = 32,
    parameter int SW    = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             run_q,
    input logic             issue_wr,
    input logic [NSLOT-1:0] issue_data,
    input logic             done_evt,
    input logic             port_rst,
    input logic             eng_bsy,
    input logic             eng_drq,
    input logic             offer_ack,
    input logic             offer_running,
    input logic             offer_valid,
    input logic [SW-1:0]    offer_slot,
    input logic [NSLOT-1:0] issue_bits,
    input logic             busy_valid,
    input logic [SW-1:0]    busy_slot
);
    // R1
    issue_or_chk: assert property (@(posedge clk) disable iff (rst)
        issue_wr |=> ((issue_bits & $past(issue_data)) == $past(issue_data)));

    // R2
    offer_run_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(offer_valid) |-> $past(run_q));

    // R3
    offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (offer_valid && !offer_ack) |=> (offer_valid && $stable(offer_slot)));

    // R4
    stall_no_offer_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(offer_valid) |-> (!$past(eng_bsy) && !$past(eng_drq)));

    // R5
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (offer_valid && offer_ack && !offer_running && !issue_wr)
            |=> !issue_bits[$past(offer_slot)]);

    // R6
    run_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (offer_valid && offer_ack && offer_running && !port_rst)
            |=> (busy_valid && busy_slot == $past(offer_slot)
                 && issue_bits[$past(offer_slot)]));

    // R7
    wake_chk: assert property (@(posedge clk) disable iff (rst)
        (done_evt && busy_valid && !eng_bsy && !eng_drq
         && !(offer_valid && offer_ack && offer_running)) |=> !busy_valid);

    // R8
    stall_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (done_evt && busy_valid && (eng_bsy || eng_drq) && !port_rst
         && !(offer_valid && offer_ack)) |=> (busy_valid && $stable(busy_slot)));

    // R9
    prst_chk: assert property (@(posedge clk) disable iff (rst)
        port_rst |=> !busy_valid);
endmodule

bind slot_dispatch slot_dispatch_chk #(.NSLOT(NSLOT), .SW(SW)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .run_q         (run_q),
    .issue_wr      (issue_wr),
    .issue_data    (issue_data),
    .done_evt      (done_evt),
    .port_rst      (port_rst),
    .eng_bsy       (eng_bsy),
    .eng_drq       (eng_drq),
    .offer_ack     (offer_ack),
    .offer_running (offer_running),
    .offer_valid   (offer_valid),
    .offer_slot    (offer_slot),
    .issue_bits    (issue_bits),
    .busy_valid    (busy_valid),
    .busy_slot     (busy_slot)
);

// File: tb/slot_dispatch_tb_top.sv
module slot_dispatch_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 0, cmd_start = 0, issue_wr = 0;
    logic [31:0] issue_data = '0;
    logic        done_evt = 0, port_rst = 0, eng_bsy = 0, eng_drq = 0;
    logic        offer_ack = 0, offer_running = 0;
    logic        offer_valid, busy_valid;
    logic [4:0]  offer_slot, busy_slot;
    logic [31:0] issue_bits;

    int vec_cnt = 0;
    int err_cnt = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    slot_dispatch dut_i (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_start(cmd_start),
        .issue_wr(issue_wr), .issue_data(issue_data), .done_evt(done_evt),
        .port_rst(port_rst), .eng_bsy(eng_bsy), .eng_drq(eng_drq),
        .offer_ack(offer_ack), .offer_running(offer_running),
        .offer_valid(offer_valid), .offer_slot(offer_slot),
        .issue_bits(issue_bits), .busy_valid(busy_valid), .busy_slot(busy_slot)
    );

    // ---------------- behavioural reference model ----------------
    int       m_st = 0;   // 0 waiting, 1 searching, 2 offering
    int       m_cur = 0;
    int       m_slot = 0;
    bit [31:0] m_pend = '0;
    bit       m_run = 0, m_kick = 0, m_bv = 0;
    int       m_bi = 0;

    always @(posedge clk) begin
        bit [31:0] clr;
        bit        nbv;
        int        nbi;
        int        hit;
        if (rst) begin
            m_st <= 0; m_cur <= 0; m_slot <= 0; m_pend <= '0;
            m_run <= 0; m_kick <= 0; m_bv <= 0; m_bi <= 0;
        end else begin
            clr = '0; nbv = m_bv; nbi = m_bi;
            if (done_evt && m_bv && !eng_bsy && !eng_drq) begin
                clr[m_bi] = 1'b1; nbv = 0;
            end
            if (m_st == 0) begin
                if (m_kick && m_run && m_pend != 0) begin m_st <= 1; m_cur <= 0; end
            end else if (m_st == 1) begin
                hit = -1;
                for (int i = 31; i >= 0; i--) if (i >= m_cur && m_pend[i]) hit = i;
                if (!m_run || hit < 0 || eng_bsy || eng_drq) m_st <= 0;
                else begin m_st <= 2; m_slot <= hit; end
            end else begin
                if (offer_ack) begin
                    if (offer_running) begin nbv = 1; nbi = m_slot; end
                    else clr[m_slot] = 1'b1;
                    m_cur <= m_slot + 1;
                    m_st  <= 1;
                end
            end
            if (port_rst) nbv = 0;
            m_bv   <= nbv;
            m_bi   <= nbi;
            m_kick <= cmd_wr | issue_wr | done_evt | (m_kick && m_st != 0);
            m_pend <= (m_pend & ~clr) | (issue_wr ? issue_data : 32'h0);
            if (cmd_wr) m_run <= cmd_start;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            vec_cnt++;
            if (offer_valid !== (m_st == 2) || (m_st == 2 && offer_slot !== 5'(m_slot))) begin
                err_cnt++;
                $display("FAIL R3 offer act=%0b/%0d exp=%0b/%0d", offer_valid, offer_slot, m_st == 2, m_slot);
            end
            if (issue_bits !== m_pend) begin
                err_cnt++;
                $display("FAIL R5 pending act=%h exp=%h", issue_bits, m_pend);
            end
            if (busy_valid !== m_bv || (m_bv && busy_slot !== 5'(m_bi))) begin
                err_cnt++;
                $display("FAIL R6 busy act=%0b/%0d exp=%0b/%0d", busy_valid, busy_slot, m_bv, m_bi);
            end
        end
    end

    // ---------------- engine stub ----------------
    int eng_delay = 0;
    int defer_slot = -1;
    int dly = 0;
    int order_q[$];

    always @(negedge clk) begin
        if (offer_ack) begin
            offer_ack = 0;
            offer_running = 0;
        end else if (offer_valid) begin
            if (dly >= eng_delay) begin
                dly = 0;
                offer_ack = 1;
                offer_running = (int'(offer_slot) == defer_slot);
                if (offer_running) eng_bsy = 1;
                order_q.push_back(int'(offer_slot));
            end else begin
                dly++;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            err_cnt++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_order(input string tag, input int exp_q[$]);
        vec_cnt++;
        if (order_q != exp_q) begin
            err_cnt++;
            $display("FAIL %s act=%p exp=%p", tag, order_q, exp_q);
        end
        order_q.delete();
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_issue(input logic [31:0] v);
        @(negedge clk); issue_wr = 1; issue_data = v;
        @(negedge clk); issue_wr = 0; issue_data = '0;
    endtask

    task automatic wr_cmd(input logic v);
        @(negedge clk); cmd_wr = 1; cmd_start = v;
        @(negedge clk); cmd_wr = 0;
    endtask

    task automatic pulse_done();
        @(negedge clk); done_evt = 1;
        @(negedge clk); done_evt = 0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            err_cnt++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            summary();
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        int exp_q[$];
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        check("R10 pending", 64'(issue_bits), 64'h0);
        check("R10 offer", 64'(offer_valid), 64'h0);
        check("R10 busy", 64'(busy_valid), 64'h0);

        // R1 / R2: bits collect while the run bit is off
        wr_issue(32'h0000_0A05);
        idle(10);
        check("R2 no offer while stopped", 64'(order_q.size()), 64'h0);
        wr_issue(32'h0000_0030);
        idle(3);
        check("R1 or-merge", 64'(issue_bits), 64'h0000_0A35);

        // R3 / R5: ascending dispatch, finished commands cleared
        eng_delay = 2;
        wr_cmd(1);
        idle(80);
        exp_q = '{0, 2, 4, 5, 9, 11};
        check_order("R3 order", exp_q);
        check("R5 cleared", 64'(issue_bits), 64'h0);

        // R6 / R4: slot 3 keeps running, slot 4 refused while engine busy
        eng_delay = 0;
        defer_slot = 3;
        wr_issue(32'h0000_0018);
        idle(20);
        exp_q = '{3};
        check_order("R4 stall stops scan", exp_q);
        check("R6 busy valid", 64'(busy_valid), 64'h1);
        check("R6 busy index", 64'(busy_slot), 64'd3);
        check("R4 bits kept", 64'(issue_bits), 64'h18);

        // R8: completion while the engine is still busy
        pulse_done();
        idle(10);
        check("R8 busy kept", 64'(busy_valid), 64'h1);
        check("R8 bits kept", 64'(issue_bits), 64'h18);
        check_order("R8 no offer", exp_q.find(x) with (x < 0));

        // R7: completion with idle engine retires slot 3 and rescans slot 4
        defer_slot = -1;
        @(negedge clk); eng_bsy = 0;
        pulse_done();
        idle(20);
        check("R7 busy dropped", 64'(busy_valid), 64'h0);
        check("R7 bits cleared", 64'(issue_bits), 64'h0);
        exp_q = '{4};
        check_order("R7 rescan", exp_q);

        // R4: data request blocks, issue write rescans after it drops
        @(negedge clk); eng_drq = 1;
        wr_issue(32'h0000_0001);
        idle(10);
        check("R4 drq blocks", 64'(issue_bits), 64'h1);
        @(negedge clk); eng_drq = 0;
        wr_issue(32'h0);
        idle(10);
        check("R2 issue write rescans", 64'(issue_bits), 64'h0);
        order_q.delete();

        // R2: run bit gates dispatch; command write restarts
        wr_cmd(0);
        wr_issue(32'h0000_0002);
        idle(10);
        check("R2 stopped keeps bit", 64'(issue_bits), 64'h2);
        wr_cmd(1);
        idle(10);
        check("R2 start dispatches", 64'(issue_bits), 64'h0);
        order_q.delete();

        // R9: port reset drops the busy slot, bitmap kept
        defer_slot = 7;
        wr_issue(32'h0000_0080);
        idle(10);
        check("R6 busy slot 7", 64'(busy_slot), 64'd7);
        @(negedge clk); port_rst = 1;
        @(negedge clk); port_rst = 0;
        idle(2);
        check("R9 busy dropped", 64'(busy_valid), 64'h0);
        check("R9 bits kept", 64'(issue_bits), 64'h80);
        defer_slot = -1;
        @(negedge clk); eng_bsy = 0;
        pulse_done();
        idle(10);
        check("R9 slot redispatched", 64'(issue_bits), 64'h0);
        order_q.delete();

        // R11: every slot including 31
        eng_delay = 1;
        wr_issue(32'hFFFF_FFFF);
        idle(200);
        exp_q.delete();
        for (int i = 0; i < 32; i++) exp_q.push_back(i);
        check_order("R11 full sweep", exp_q);
        check("R11 all cleared", 64'(issue_bits), 64'h0);
        check("R11 scanner idle", 64'(offer_valid), 64'h0);

        idle(5);
        summary();
    end
endmodule